// File: doc/BRIEF.md
# Timer Channel with Unbuffered Compare

This block is a free-running up-counter with a programmable wrap point and a single channel. The channel runs either as an output compare or as an input capture. The counter advances only on cycles where the external prescaled `tick` is high. It counts from zero up to the modulo value and then returns to zero. The channel's compare register has no shadow copy. A software write lands in the live comparator on the next clock edge. Where the counter stands at that moment therefore decides whether the next match is skipped, or whether a second match fires in the same period.

Software reaches the block through a plain register port. Writes complete in the cycle `wr_en` is high. Reads are combinational on `addr`. The register map is: 0 control, 1 modulo, 2 channel value, 3 status (write-one-to-clear), 4 counter (read-only). The control word holds these fields:
- bit 0: capture mode
- bits 2:1: compare action
- bits 4:3: capture edge
- bit 5: overflow interrupt enable
- bit 6: channel interrupt enable

In capture mode the block samples an external reference (for example a mains zero-crossing detector) through a two-stage synchronizer and latches the count on the chosen edge. There is no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `tmr_unbuf_chan`

## Requirements
- R1: On each cycle with `tick` high, the counter advances by one. After it equals the wrap point it returns to 0. The wrap point is the modulo register (address 1), or 16'hFFFF when that register is 0. With `tick` low the counter holds.
- R2: The overflow flag (status bit 0) sets on the tick that wraps the counter. `ovf_irq` is high exactly when this flag and control bit 5 are both set.
- R3: In compare mode (control bit 0 = 0), a tick with counter equal to the channel value is a match. A match sets the channel flag (status bit 1) and applies the action in control bits 2:1: 01 toggles `cmp_out`, 10 drives it low, 11 drives it high, 00 leaves it alone.
- R4: A write to the channel value (address 2) replaces the compare value at the next edge. A match in the write cycle uses the old value. A new value that is not above the count at write time gives no match before the wrap.
- R5: A larger value written in the cycle of a match produces a second match in the same counter period.
- R6: In capture mode (control bit 0 = 1), an edge on `cap_in` copies the counter into the channel value and sets the channel flag. Bits 4:3 select the edge: 01 rising, 10 falling, 11 both, 00 none. An unselected edge changes nothing.
- R7: In capture mode, software writes to the channel value are ignored.
- R8: Writing 1 to a status bit clears that flag. A set in the same cycle wins over the clear. `ch_irq` is high exactly when the channel flag and control bit 6 are both set.
- R9: After reset the counter, every register, both flags, `cmp_out` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_out | output | 1 | Compare output pin |
| ovf_irq | output | 1 | Overflow interrupt |
| ch_irq | output | 1 | Channel interrupt |

## Verification
The bench drives a table of compare rewrites, each timed against the live count. It covers four write positions:
- a smaller value written after the counter has passed it: a design that defers writes to the wrap would still toggle here;
- a smaller value written just after the wrap;
- a larger value written in the very cycle of a match: a design that lets the new value take part in that cycle's match would report one compare instead of two;
- the same value written back in its own match cycle.

Directed tests attack the flag race, where a clear lands on the same edge as a wrap and a design giving the clear priority would lose the event. They also check that capture-mode writes are rejected, that an unselected capture edge is ignored, and that a zero modulo gives the full-width wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cap_edge_e;

  // control word, bit 6 down to bit 0
  typedef struct packed {
    logic      ch_ie;
    logic      ovf_ie;
    cap_edge_e edge_sel;
    cmp_act_e  act;
    logic      cap_mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_MOD   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CHVAL = 3'd2;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CNT   = 3'd4;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] modv,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] top;

  assign top  = (modv == '0) ? FULL : modv;
  assign wrap = tick && (count == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], din};
  end

  assign rise = sh[SYNC-1] & ~sh[SYNC];
  assign fall = ~sh[SYNC-1] & sh[SYNC];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         cap_mode,
  input  cmp_act_e     act,
  input  cap_edge_e    edge_sel,
  input  logic         rise,
  input  logic         fall,
  input  logic         wr_val,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] chval,
  output logic         cmp_out,
  output logic         ch_set
);
  logic cmp_hit, cap_hit, want_rise, want_fall;

  assign want_rise = (edge_sel == EDGE_RISE) || (edge_sel == EDGE_BOTH);
  assign want_fall = (edge_sel == EDGE_FALL) || (edge_sel == EDGE_BOTH);
  // the match sees the register as it stands before any write of this cycle
  assign cmp_hit   = tick && !cap_mode && (count == chval);
  assign cap_hit   = cap_mode && ((want_rise && rise) || (want_fall && fall));
  assign ch_set    = cmp_hit || cap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   chval <= '0;
    else if (cap_hit)             chval <= count;
    else if (wr_val && !cap_mode) chval <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= 1'b0;
    else if (cmp_hit) begin
      case (act)
        ACT_TOGGLE: cmp_out <= ~cmp_out;
        ACT_CLEAR:  cmp_out <= 1'b0;
        ACT_SET:    cmp_out <= 1'b1;
        default:    cmp_out <= cmp_out;
      endcase
    end
  end
endmodule

// File: rtl/tmr_unbuf_chan.sv
module tmr_unbuf_chan
  import tmr_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic              cap_in,
  output logic              cmp_out,
  output logic              ovf_irq,
  output logic              ch_irq
);
  ctrl_t        ctrl;
  logic [W-1:0] modv, count, chval;
  logic         wrap, rise, fall, ch_set;
  logic         ovf_flag, ch_flag;
  logic         wr_stat;

  assign wr_stat = wr_en && (addr == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      modv <= '0;
    end else if (wr_en) begin
      if (addr == RA_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == RA_MOD)  modv <= wdata;
    end
  end

  // sticky flags: a set on the same edge beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      ch_flag  <= 1'b0;
    end else begin
      ovf_flag <= wrap   | (ovf_flag & ~(wr_stat & wdata[0]));
      ch_flag  <= ch_set | (ch_flag  & ~(wr_stat & wdata[1]));
    end
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .modv(modv),
    .count(count), .wrap(wrap)
  );

  tmr_edge_det #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise), .fall(fall)
  );

  tmr_channel #(.W(W)) u_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .cap_mode(ctrl.cap_mode), .act(ctrl.act), .edge_sel(ctrl.edge_sel),
    .rise(rise), .fall(fall),
    .wr_val(wr_en && (addr == RA_CHVAL)), .wdata(wdata),
    .chval(chval), .cmp_out(cmp_out), .ch_set(ch_set)
  );

  assign ovf_irq = ovf_flag & ctrl.ovf_ie;
  assign ch_irq  = ch_flag  & ctrl.ch_ie;

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL:  rdata[CTRL_W-1:0] = ctrl;
      RA_MOD:   rdata = modv;
      RA_CHVAL: rdata = chval;
      RA_STAT:  rdata[1:0] = {ch_flag, ovf_flag};
      RA_CNT:   rdata = count;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_unbuf_chan_chk.sv
module tmr_unbuf_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] count,
  input logic [W-1:0] modv,
  input logic [W-1:0] chval,
  input logic         cap_mode,
  input logic         ovf_flag,
  input logic         ch_flag,
  input logic         ovf_irq,
  input logic         ch_irq,
  input logic         cmp_out
);
  localparam logic [W-1:0] FULL = '1;
  logic [W-1:0] lim;
  assign lim = (modv == '0) ? FULL : modv;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != lim) |=> count == W'($past(count) + 1'b1));

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R2
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(tick) && $past(count) == $past(lim) && count == '0));

  // R2
  ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag);

  // R3
  out_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_out) |-> ($past(tick) && !$past(cap_mode) && ch_flag));

  // R7
  cap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_mode) && chval != $past(chval)) |-> ch_flag);

  // R8
  ch_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_irq |-> ch_flag);
endmodule

bind tmr_unbuf_chan tmr_unbuf_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .modv(modv),
  .chval(chval), .cap_mode(ctrl.cap_mode), .ovf_flag(ovf_flag),
  .ch_flag(ch_flag), .ovf_irq(ovf_irq), .ch_irq(ch_irq), .cmp_out(cmp_out)
);

// File: tb/tb_tmr_unbuf_chan.sv
module tb_tmr_unbuf_chan;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 190000;

  localparam logic [2:0] A_CTRL = 3'd0, A_MOD = 3'd1, A_VAL = 3'd2,
                         A_STAT = 3'd3, A_CNT = 3'd4;

  typedef struct packed {
    logic [15:0] oldv;
    logic [15:0] wpos;
    logic [15:0] newv;
    logic [15:0] exp;
  } vec_t;

  // modulo 15, toggle action: matches seen from the write edge to the wrap
  localparam vec_t VEC [0:5] = '{
    '{16'd10, 16'd5, 16'd3,  16'd0},  // R4 passed value: missed
    '{16'd10, 16'd5, 16'd8,  16'd1},  // R4 ahead value
    '{16'd4,  16'd4, 16'd12, 16'd2},  // R5 double compare
    '{16'd4,  16'd6, 16'd12, 16'd1},  // R4 old already passed
    '{16'd9,  16'd9, 16'd9,  16'd1},  // R4 same value in match cycle
    '{16'd8,  16'd0, 16'd0,  16'd0}   // R4 smaller value at wrap: missed
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, cap_in = 1'b0;
  logic [2:0]  addr = A_CNT;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic cmp_out, ovf_irq, ch_irq;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  tmr_unbuf_chan dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .cmp_out(cmp_out),
    .ovf_irq(ovf_irq), .ch_irq(ch_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = A_CNT;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
    addr = A_CNT;
  endtask

  task automatic wait_count(input logic [15:0] target);
    forever begin
      @(negedge clk);
      addr = A_CNT;
      #1;
      if (rdata == target) break;
    end
  endtask

  logic [15:0] v, x, x2;
  logic prev;
  int toggles;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    rreg(A_CNT, v);  check("R9 count", v, 16'd0);
    rreg(A_VAL, v);  check("R9 chval", v, 16'd0);
    rreg(A_STAT, v); check("R9 flags", v, 16'd0);
    rreg(A_CTRL, v); check("R9 ctrl", v, 16'd0);
    check("R9 pins", {13'd0, cmp_out, ovf_irq, ch_irq}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 hold without tick
    repeat (4) @(negedge clk);
    rreg(A_CNT, v); check("R1 hold", v, 16'd0);

    wreg(A_MOD, 16'd15);
    wreg(A_CTRL, 16'h0002);   // toggle
    tick = 1'b1;

    // vector table: R4 / R5
    foreach (VEC[i]) begin
      wreg(A_VAL, VEC[i].oldv);
      wait_count(VEC[i].wpos);
      prev = cmp_out;
      wr_en = 1'b1; addr = A_VAL; wdata = VEC[i].newv;
      @(negedge clk);
      wr_en = 1'b0; addr = A_CNT;
      toggles = 0;
      forever begin
        #1;
        if (cmp_out != prev) begin toggles++; prev = cmp_out; end
        if (rdata == 16'd0) break;
        @(negedge clk);
      end
      check($sformatf("R4/R5 vector %0d", i), 16'(toggles), VEC[i].exp);
    end

    // R1 wrap at modulo
    wait_count(16'd15);
    @(negedge clk); rreg(A_CNT, v); check("R1 wrap", v, 16'd0);

    // R3 actions
    wreg(A_VAL, 16'd7);
    wreg(A_CTRL, 16'h0004);  // clear
    repeat (20) @(negedge clk);
    check("R3 clear", {15'd0, cmp_out}, 16'd0);
    wreg(A_CTRL, 16'h0006);  // set
    repeat (20) @(negedge clk);
    check("R3 set", {15'd0, cmp_out}, 16'd1);
    wreg(A_CTRL, 16'h0000);  // none
    repeat (20) @(negedge clk);
    check("R3 none", {15'd0, cmp_out}, 16'd1);
    rreg(A_STAT, v); check("R3 ch flag", v & 16'h2, 16'h2);

    // R8 clear and channel irq
    wreg(A_CTRL, 16'h0040);
    check("R8 ch_irq on", {15'd0, ch_irq}, 16'd1);
    wreg(A_VAL, 16'd200);    // no further match
    wreg(A_STAT, 16'h0002);
    rreg(A_STAT, v); check("R8 ch clear", v & 16'h2, 16'h0);
    check("R8 ch_irq off", {15'd0, ch_irq}, 16'd0);

    // R2 + R8: clear on the same edge as the wrap -> set wins
    wreg(A_CTRL, 16'h0020);
    wait_count(16'd15);
    wr_en = 1'b1; addr = A_STAT; wdata = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    rreg(A_STAT, v); check("R8 set beats clear", v & 16'h1, 16'h1);
    check("R2 ovf_irq", {15'd0, ovf_irq}, 16'd1);
    wreg(A_STAT, 16'h0001);
    rreg(A_STAT, v); check("R2 ovf cleared", v & 16'h1, 16'h0);
    check("R2 ovf_irq off", {15'd0, ovf_irq}, 16'd0);

    // R6 capture, rising edge, with the count frozen
    tick = 1'b0;
    wreg(A_CTRL, 16'h0009);
    wreg(A_STAT, 16'h0003);
    rreg(A_CNT, x);
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rreg(A_VAL, v);  check("R6 rise capture", v, x);
    rreg(A_STAT, v); check("R6 flag", v & 16'h2, 16'h2);
    // R7 write ignored in capture mode
    wreg(A_VAL, 16'h1234);
    rreg(A_VAL, v);  check("R7 write ignored", v, x);

    // R6 falling edge only
    wreg(A_CTRL, 16'h0011);
    tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
    rreg(A_CNT, x2);
    wreg(A_STAT, 16'h0002);
    cap_in = 1'b0;
    repeat (5) @(negedge clk);
    rreg(A_VAL, v); check("R6 fall capture", v, x2);
    wreg(A_STAT, 16'h0002);
    tick = 1'b1; repeat (2) @(negedge clk); tick = 1'b0;
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rreg(A_VAL, v);  check("R6 rise ignored", v, x2);
    rreg(A_STAT, v); check("R6 no flag", v & 16'h2, 16'h0);

    // R1 modulo 0 means full width
    wreg(A_CTRL, 16'h0000);
    wreg(A_MOD, 16'd0);
    tick = 1'b1;
    wait_count(16'hFFFF);
    @(negedge clk); rreg(A_CNT, v); check("R1 full wrap", v, 16'd0);

    finish_run();
  end
endmodule